// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block generates the address for each beat of a short burst. A cycle controller pulses one of two load strobes to capture a starting address. It then pulses an advance request to move to the next beat. Only the lowest address bits cycle through the burst. All higher bits keep the value they had when the address was captured.

The beat order is set by a static order-select input. With the input low, the low bits count upward from the start and wrap (start plus beat, modulo the burst length). With the input high, the low bits are the start combined with the beat number by exclusive-or. A board would tie this input high when nothing else drives it. The controller decides when to load and when to advance; this block only reacts to those pulses. It presents the full current address and the beat number.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset the beat index is 0 and the current address is all zeros.
- R2: When `ld_proc` or `ld_ctrl` is high at a clock edge, the next address equals `ld_addr` and the beat index becomes 0.
- R3: With `order_sel` = 0 (linear), the low two bits equal (start + beat) mod 4. From a start of 01 the beats read 01, 10, 11, 00.
- R4: With `order_sel` = 1 (interleaved), the low two bits equal start XOR beat. From a start of 01 the beats read 01, 00, 11, 10.
- R5: `order_sel` is the only thing that picks the order. Loading the same start under each setting gives the R3 sequence for 0 and the R4 sequence for 1.
- R6: The beat index steps by one at an edge where `adv` is high and neither load strobe is high. At an edge where `adv` is low and no strobe is high, the address and the beat index hold.
- R7: A load takes priority over an advance at the same edge. `adv` has no effect at that edge, so the beat index reads 0 afterwards.
- R8: Address bits above bit 1 change only on a load. A step of the low bits from 11 never carries into bit 2.
- R9: An advance after the fourth beat wraps the beat index to 0 and returns the low bits to the starting value.
- R10: `beat_idx` counts the advances since the last load, modulo 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| ld_proc | input | 1 | Load pulse from the processor-side strobe |
| ld_ctrl | input | 1 | Load pulse from the controller-side strobe |
| adv | input | 1 | Advance request, active high |
| ld_addr | input | ADDR_W (21) | Starting address captured on a load |
| cur_addr | output | ADDR_W (21) | Address of the current beat |
| beat_idx | output | BEAT_W (2) | Beat number within the burst |

## Verification
Several properties are checked on every cycle:
- the reset state;
- a cleared beat index and captured upper bits after any load;
- the hold and single-step behaviour of the beat index;
- the frozen upper bits between loads;
- the step-by-step relation of the low bits in each order while `order_sel` stays put.

The bench's scenarios check the rest:
- the complete sequences from a given start, including the literal values for a start of 01;
- the wrap back to the start after the fourth beat;
- the absence of a carry into bit 2 from a start of 11;
- the same-edge load-and-advance collisions on both strobes.

// File: rtl/burst_pkg.sv
package burst_pkg;
    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    output logic [BEAT_W-1:0] cnt
);
    typedef struct packed {
        logic [BEAT_W-1:0] cnt;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.cnt = '0;
        end else if (step) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  order_e            order,
    input  logic [BEAT_W-1:0] start_lo,
    input  logic [BEAT_W-1:0] beat,
    output logic [BEAT_W-1:0] lo
);
    logic [BEAT_W-1:0] lin_lo;
    logic [BEAT_W-1:0] ilv_lo;

    always_comb begin
        lin_lo = start_lo + beat;
        ilv_lo = start_lo ^ beat;
        lo     = (order == ORD_INTERLEAVE) ? ilv_lo : lin_lo;
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              order_sel,
    input  logic              ld_proc,
    input  logic              ld_ctrl,
    input  logic              adv,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [BEAT_W-1:0] beat_idx
);
    localparam int HI_W = ADDR_W - BEAT_W;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
    } base_t;

    base_t             st_d, st_q;
    logic              load;
    logic              step;
    logic [BEAT_W-1:0] cnt;
    logic [BEAT_W-1:0] lo;
    order_e            order;

    always_comb begin
        load  = ld_proc | ld_ctrl;
        step  = adv & ~load;
        order = order_e'(order_sel);
        st_d  = st_q;
        if (load) begin
            st_d.base = ld_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    burst_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (load),
        .step  (step),
        .cnt   (cnt)
    );

    burst_order_map #(.BEAT_W(BEAT_W)) u_map (
        .order    (order),
        .start_lo (st_q.base[BEAT_W-1:0]),
        .beat     (cnt),
        .lo       (lo)
    );

    generate
        if (HI_W > 0) begin : g_hi
            assign cur_addr = {st_q.base[ADDR_W-1:BEAT_W], lo};
        end else begin : g_lo_only
            assign cur_addr = lo;
        end
    endgenerate

    assign beat_idx = cnt;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int ADDR_W = 21,
    parameter int BEAT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              order_sel,
    input logic              ld_proc,
    input logic              ld_ctrl,
    input logic              adv,
    input logic [ADDR_W-1:0] ld_addr,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [BEAT_W-1:0] beat_idx
);
    logic ld_any;
    logic [BEAT_W-1:0] lo_now;
    logic [BEAT_W-1:0] one_beat;

    assign ld_any   = ld_proc | ld_ctrl;
    assign lo_now   = cur_addr[BEAT_W-1:0];
    assign one_beat = {{(BEAT_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_state: assert (beat_idx == '0 && cur_addr == '0)
                else $error("R1 reset state wrong");
        end
    end

    a_r2_load_capture: assert property (@(posedge clk) disable iff (!rst_n)
        ld_any |=> (beat_idx == '0) &&
                   (cur_addr[ADDR_W-1:BEAT_W] == $past(ld_addr[ADDR_W-1:BEAT_W])))
        else $error("R2 load capture wrong");

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_any && !adv) |=> $stable(beat_idx))
        else $error("R6 hold broken");

    a_r10_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_any && adv) |=> beat_idx == $past(beat_idx) + one_beat)
        else $error("R10 step wrong");

    a_r7_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_any && adv) |=> beat_idx == '0)
        else $error("R7 load priority broken");

    a_r8_upper_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_any |=> $stable(cur_addr[ADDR_W-1:BEAT_W]))
        else $error("R8 upper bits moved");

    a_r3_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_any && adv && !order_sel) |=>
            (order_sel != $past(order_sel)) || (lo_now == $past(lo_now) + one_beat))
        else $error("R3 linear step wrong");

    a_r4_interleave_inv: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_any && order_sel) |=>
            (order_sel != $past(order_sel)) ||
            ((lo_now ^ beat_idx) == ($past(lo_now) ^ $past(beat_idx))))
        else $error("R4 interleave relation wrong");
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .order_sel (order_sel),
    .ld_proc   (ld_proc),
    .ld_ctrl   (ld_ctrl),
    .adv       (adv),
    .ld_addr   (ld_addr),
    .cur_addr  (cur_addr),
    .beat_idx  (beat_idx)
);

// File: tb/tb_burst_addr_gen.sv
`timescale 1ns/1ps
module tb_burst_addr_gen;
    localparam int ADDR_W = 21;
    localparam int BEAT_W = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              order_sel = 1'b1;
    logic              ld_proc = 1'b0;
    logic              ld_ctrl = 1'b0;
    logic              adv = 1'b0;
    logic [ADDR_W-1:0] ld_addr = '0;
    logic [ADDR_W-1:0] cur_addr;
    logic [BEAT_W-1:0] beat_idx;

    int n_checks = 0;
    int n_fail   = 0;
    int m_base   = 0;
    int m_cnt    = 0;
    string tag   = "R1";
    bit done     = 1'b0;

    always #2 clk = ~clk;

    burst_addr_gen #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) dut (
        .clk(clk), .rst_n(rst_n), .order_sel(order_sel), .ld_proc(ld_proc),
        .ld_ctrl(ld_ctrl), .adv(adv), .ld_addr(ld_addr),
        .cur_addr(cur_addr), .beat_idx(beat_idx)
    );

    function automatic int exp_addr();
        int lo0 = m_base % 4;
        int lo  = order_sel ? (lo0 ^ m_cnt) : ((lo0 + m_cnt) % 4);
        return (m_base / 4) * 4 + lo;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic compare_model();
        chk(tag, int'(cur_addr), exp_addr());
        chk("R10", int'(beat_idx), m_cnt);
    endtask

    task automatic step(input bit lp, input bit lc, input bit a, input int addr);
        ld_proc = lp; ld_ctrl = lc; adv = a; ld_addr = addr[ADDR_W-1:0];
        if (lp || lc) begin
            tag = a ? "R7" : "R2";
            m_base = addr; m_cnt = 0;
        end else if (a) begin
            tag = order_sel ? "R4" : "R3";
            m_cnt = (m_cnt + 1) % 4;
        end else begin
            tag = "R6";
        end
        @(negedge clk);
        compare_model();
    endtask

    task automatic burst_seq(input string req, input int start, input int e0,
                             input int e1, input int e2, input int e3);
        step(1'b1, 1'b0, 1'b0, start);
        chk(req, int'(cur_addr[1:0]), e0);
        step(1'b0, 1'b0, 1'b1, 0);
        chk(req, int'(cur_addr[1:0]), e1);
        step(1'b0, 1'b0, 1'b1, 0);
        chk(req, int'(cur_addr[1:0]), e2);
        step(1'b0, 1'b0, 1'b1, 0);
        chk(req, int'(cur_addr[1:0]), e3);
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", int'(cur_addr), 0);
        chk("R1", int'(beat_idx), 0);
        rst_n = 1'b1;

        // R3 / R5 linear from 01, then R9 wrap
        order_sel = 1'b0;
        burst_seq("R3", 21'h0A5, 1, 2, 3, 0);
        step(1'b0, 1'b0, 1'b1, 0);
        chk("R9", int'(cur_addr), 21'h0A5);
        chk("R9", int'(beat_idx), 0);

        // R4 / R5 interleaved from 01
        order_sel = 1'b1;
        burst_seq("R4", 21'h0A5, 1, 0, 3, 2);
        burst_seq("R5", 21'h1F3_01, 1, 0, 3, 2);
        order_sel = 1'b0;
        burst_seq("R5", 21'h1F3_01, 1, 2, 3, 0);

        // R8 no carry from 11
        step(1'b0, 1'b1, 1'b0, 21'h0_7FF);
        step(1'b0, 1'b0, 1'b1, 0);
        chk("R8", int'(cur_addr), 21'h0_7FC);

        // R6 hold
        step(1'b0, 1'b0, 1'b0, 21'h1_2345);
        step(1'b0, 1'b0, 1'b0, 21'h1_2345);
        chk("R6", int'(cur_addr), 21'h0_7FC);
        chk("R6", int'(beat_idx), 1);

        // R7 load and advance on same edge, both strobes
        step(1'b0, 1'b0, 1'b1, 0);
        step(1'b1, 1'b0, 1'b1, 21'h15_5556);
        chk("R7", int'(beat_idx), 0);
        chk("R7", int'(cur_addr), 21'h15_5556);
        step(1'b0, 1'b0, 1'b1, 0);
        step(1'b0, 1'b1, 1'b1, 21'h0_0003);
        chk("R7", int'(beat_idx), 0);
        chk("R7", int'(cur_addr), 3);

        // mixed traffic against the model
        for (int i = 0; i < 400; i++) begin
            int r = $urandom_range(0, 9);
            if (i % 37 == 0) order_sel = $urandom_range(0, 1);
            step(r == 0, r == 1, r > 3 || r == 0, $urandom_range(0, (1 << ADDR_W) - 1));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule